// File: doc/BRIEF.md
# Dual-Clock Latched Shift Register

This block turns a serial bit stream into a parallel word. Bits enter a chain of shift stages on the rising edge of a shift clock. A separate storage clock copies the whole chain into a holding register in one step. The holding register drives the parallel pins through three-state buffers. Because the two clocks are separate, the next word can be shifted in while the parallel pins keep showing the last word that was committed.

The last shift stage is also brought out as a serial output. Wiring it to the serial input of a second instance chains the two into a longer register. An active-low clear empties only the shift stages. An active-low enable only decides whether the parallel pins drive or float. The data pins are plain level signals with no handshake, because the storage clock is the only commit event. A copy of the holding register that is never tri-stated is also brought out for on-chip checking.

Top module: `lsr_dual_clk`

## Requirements
- R1: On each rising edge of `sh_clk` (with `clr_n` high), stage 0 takes `ser_in` and every stage n above 0 takes the previous value of stage n-1. A byte sent with its bit 7 first therefore ends with bit n in stage n after eight edges.
- R2: `ser_out` always equals the top shift stage, so after one further shift it shows what stage 6 held before that shift.
- R3: On a rising edge of `st_clk`, all shift stages are copied into the holding register, and stage n appears on `par_out[n]`. Between storage edges, `par_out` does not change, however many shifts take place.
- R4: A low `clr_n` clears the shift stages at once, without waiting for a clock, and holds them at zero. `ser_out` is low during that time, and the holding register and `par_out` keep their values.
- R5: A storage edge taken while the shift stages are cleared loads all zeros, so `par_out` reads 0.
- R6: When `sh_clk` and `st_clk` rise at the same instant, the holding register takes the shift contents from before that edge, so it stays one shift behind.
- R7: While `oe_n` is high, every bit of `par_out` is high impedance (z). While `oe_n` is low, `par_out` drives the holding register.
- R8: `oe_n` changes neither register. Shifts and loads made while it is high take effect normally, and `ser_out` stays driven at every level of `oe_n`.
- R9: With `ser_out` of one instance wired to `ser_in` of a second, after 16 shifts and one storage edge the first instance holds the last 8 bits sent and the second holds the 8 bits sent just before them.
- R10: The first shift edge after `clr_n` is released captures `ser_in` normally.
- R11: `latch_view` always shows the holding register, whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data entering shift stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge |
| st_clk | input | 1 | Storage clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_out | output | WIDTH (8) | Three-state parallel outputs from the holding register |
| ser_out | output | 1 | Top shift stage, used for cascading |
| latch_view | output | WIDTH (8) | Holding register contents, never tri-stated |

## Verification
The bench raises both clocks in the same instant and checks that the committed word is the one from before the shift. A design that let storage see the new shift value would show a word shifted by one place. It loads the holding register while the clear is held low, and clears a populated chain with no storage edge. Each of these catches a clear that reaches the holding register, or a load that ignores the cleared chain. It shifts and loads while the outputs float and then checks that the new word appears once they are enabled, which catches an enable that gates the clocks or the data. A two-instance chain of 16 bits checks the bit order at the cascade point, where a chain fed from the wrong end would swap the two halves.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  // Default number of shift stages and holding bits.
  localparam int unsigned LSR_W = 8;
endpackage

// File: rtl/lsr_shift_chain.sv
module lsr_shift_chain #(
  parameter int unsigned W = lsr_pkg::LSR_W
) (
  input  logic         sh_clk,
  input  logic         clr_n,
  input  logic         ser_in,
  output logic [W-1:0] stg,
  output logic         tail
);
  localparam int unsigned TOP = W - 1;

  // Stage 0 takes the serial input; each higher stage takes the one below it.
  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) stg <= '0;
    else        stg <= {stg[TOP-1:0], ser_in};
  end

  assign tail = stg[TOP];

  // R4
  clr_holds_chain_chk: assert property (@(posedge sh_clk) !clr_n |-> (stg == '0 && tail == 1'b0));
endmodule

// File: rtl/lsr_hold_reg.sv
module lsr_hold_reg #(
  parameter int unsigned W = lsr_pkg::LSR_W
) (
  input  logic         st_clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // No reset: the holding register keeps its value until the storage clock fires.
  always_ff @(posedge st_clk) begin
    q <= d;
  end
endmodule

// File: rtl/lsr_par_drive.sv
module lsr_par_drive #(
  parameter int unsigned W = lsr_pkg::LSR_W
) (
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] pad
);
  // One three-state buffer per parallel bit.
  for (genvar i = 0; i < W; i++) begin : g_buf
    assign pad[i] = en_n ? 1'bz : d[i];
  end
endmodule

// File: rtl/lsr_dual_clk.sv
module lsr_dual_clk #(
  parameter int unsigned WIDTH = lsr_pkg::LSR_W
) (
  input  logic             ser_in,
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out,
  output logic [WIDTH-1:0] latch_view
);
  logic [WIDTH-1:0] chain;
  logic [WIDTH-1:0] held;

  lsr_shift_chain #(.W(WIDTH)) u_chain (
    .sh_clk (sh_clk),
    .clr_n  (clr_n),
    .ser_in (ser_in),
    .stg    (chain),
    .tail   (ser_out)
  );

  lsr_hold_reg #(.W(WIDTH)) u_hold (
    .st_clk (st_clk),
    .d      (chain),
    .q      (held)
  );

  lsr_par_drive #(.W(WIDTH)) u_drive (
    .en_n (oe_n),
    .d    (held),
    .pad  (par_out)
  );

  assign latch_view = held;

  // R3
  hold_tracks_chain_chk: assert property (@(posedge st_clk) disable iff (!clr_n)
    1'b1 |=> (held == $past(chain)));

  // R5
  cleared_load_zero_chk: assert property (@(posedge st_clk) !clr_n |=> (held == '0));

  // R7
  enabled_pins_match_chk: assert property (@(posedge st_clk) disable iff (!clr_n)
    !oe_n |-> (par_out == held));
endmodule

// File: tb/tb_lsr_dual_clk.sv
module tb_lsr_dual_clk;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       ser_in = 1'b0, sh_clk = 1'b0, st_clk = 1'b0, clr_n = 1'b0, oe_n = 1'b0;
  logic [7:0] par_out, latch_view, t_par, t_view;
  logic       ser_out, t_ser;

  int total = 0;
  int bad   = 0;

  lsr_dual_clk dut (
    .ser_in(ser_in), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n),
    .par_out(par_out), .ser_out(ser_out), .latch_view(latch_view)
  );

  lsr_dual_clk u_tail (
    .ser_in(ser_out), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n),
    .par_out(t_par), .ser_out(t_ser), .latch_view(t_view)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b; sh_clk = 1'b1;
    @(negedge clk); sh_clk = 1'b0;
  endtask

  task automatic store();
    @(negedge clk); st_clk = 1'b1;
    @(negedge clk); st_clk = 1'b0;
  endtask

  task automatic both_edges(input logic b);
    @(negedge clk); ser_in = b; sh_clk = 1'b1; st_clk = 1'b1;
    @(negedge clk); sh_clk = 1'b0; st_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R4 ser_out low in clear", {7'd0, ser_out}, 8'd0);
    shift_bit(1'b1);
    chk("R4 chain held clear", {7'd0, ser_out}, 8'd0);
    store();
    chk("R5 load during clear", par_out, 8'h00);
    chk("R11 view after cleared load", latch_view, 8'h00);
    @(negedge clk); clr_n = 1'b1;
  endtask

  task automatic t_pattern(input logic [7:0] v, input logic [7:0] prev);
    send_byte(v);
    chk("R3 pins hold between stores", par_out, prev);
    chk("R2 ser_out is top stage", {7'd0, ser_out}, {7'd0, v[7]});
    store();
    chk("R1 R3 byte committed", par_out, v);
    shift_bit(1'b0);
    chk("R2 ser_out shows old stage 6", {7'd0, ser_out}, {7'd0, v[6]});
  endtask

  task automatic t_same_edge();
    send_byte(8'hC3);
    both_edges(1'b0);
    chk("R6 storage one shift behind", par_out, 8'hC3);
    store();
    chk("R6 next store sees shifted word", par_out, 8'h86);
  endtask

  task automatic t_enable();
    send_byte(8'h5A); store();
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    chk("R7 pins float", par_out, 8'bzzzz_zzzz);
    chk("R11 view while floating", latch_view, 8'h5A);
    chk("R8 ser_out driven while floating", {7'd0, ser_out}, 8'd0);
    send_byte(8'hF0);
    chk("R8 ser_out follows shift while floating", {7'd0, ser_out}, 8'd1);
    store();
    chk("R7 still floating after load", par_out, 8'bzzzz_zzzz);
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    chk("R8 load while floating kept", par_out, 8'hF0);
  endtask

  task automatic t_clear_keeps_hold();
    send_byte(8'h3C); store();
    send_byte(8'hFF);
    @(negedge clk); clr_n = 1'b0;
    #2;
    chk("R4 clear is immediate", {7'd0, ser_out}, 8'd0);
    @(negedge clk);
    chk("R4 pins unchanged by clear", par_out, 8'h3C);
    @(negedge clk); clr_n = 1'b1;
    shift_bit(1'b1);
    for (int i = 0; i < 6; i++) shift_bit(1'b0);
    chk("R10 first shift not yet at top", {7'd0, ser_out}, 8'd0);
    shift_bit(1'b0);
    chk("R10 first shift after release captured", {7'd0, ser_out}, 8'd1);
    store();
    chk("R5 R10 chain refilled from clear", par_out, 8'h80);
  endtask

  task automatic t_cascade();
    send_byte(8'hA7);
    send_byte(8'h19);
    store();
    chk("R9 head holds last byte", par_out, 8'h19);
    chk("R9 tail holds earlier byte", t_par, 8'hA7);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_pattern(8'hB5, 8'h00);
    t_pattern(8'h0F, 8'hB5);
    t_same_edge();
    t_enable();
    t_clear_keeps_hold();
    t_cascade();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule